// File: doc/BRIEF.md
# Sixteen-bit timer with compare and capture channels

This block is an up-counting 16-bit timer with four channels that can each compare against the count or capture it. Software reaches every register through a byte-wide write/read port. A control register starts the timer. It also picks the count rate: every clock, or one count per twelve clocks. A third option makes an overflow reload the counter from channel 0's register instead of wrapping to zero. An overflow sets a sticky interrupt flag, which drives the `irq` output.

Each channel has a 2-bit mode field. The field sets the channel to one of four modes: idle, capture on an edge of its input pin, compare driving its PWM output, or capture when software writes the channel's low byte. Channel 0 captures on a falling pin edge. Channels 1 and 2 capture on rising edges and take one cycle longer. Channel 3 has no pin.

Top module: `tmr_cc4`

## Requirements
- R1: After reset, the counter, the mode register, every channel register and the control register read 0, and `irq` and all `pwm_out` bits are 0.
- R2: Register map (byte address): 0 control, 1 mode, 2/3 counter low/high, 4+2n/5+2n channel n low/high. Writes read back. Channel n's mode field is mode bits [2n+1:2n], with encoding 00 idle, 01 pin edge, 10 compare, 11 software-write capture.
- R3: Control bit 0 runs the timer. Control bit 1 = 0 counts once per clock. Control bit 1 = 1 counts once every 12 clocks, with the first count 12 clocks after the start.
- R4: A count step from 0xFFFF is an overflow. Without reload, the counter goes to 0x0000. An overflow sets control bit 7 and `irq`. They stay set until software writes control with bit 7 = 1.
- R5: With control bit 2 set, an overflow loads the counter from channel 0's register, in every mode of channel 0.
- R6: In compare mode, a channel's `pwm_out` goes high one clock after the counter equals its register. It goes low one clock after an overflow. Outside compare mode it is 0.
- R7: Channel 0 in pin mode captures on a falling edge of `cap_pin[0]` and ignores rising edges. A pin change just before clock edge k stores the count held before edge k+2.
- R8: Channels 1 and 2 in pin mode capture on a rising edge. A pin change just before clock edge k stores the count held before edge k+3.
- R9: In mode 11, a write to the channel's low byte stores the whole 16-bit count in place of the written data. A high-byte write stores data as usual.
- R10: Pin edges have no effect in mode 00. Channel 3 never captures in mode 01.
- R11: A software write to a counter byte takes effect in the cycle it occurs, in place of that cycle's count step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for one clock |
| reg_addr | input | 4 | Byte register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| cap_pin | input | 3 | Capture pins of channels 0 to 2 |
| pwm_out | output | 4 | Compare outputs of channels 0 to 3 |
| irq | output | 1 | Overflow interrupt request |

## Verification
The compare path is driven from a table of preload and compare pairs. The pairs separate several cases: a match that has not yet been reached, one just reached, one crossed long ago, and a match before or after an overflow. A preload equal to the compare value shows that the match does not depend on counting. Capture is driven with pin edges while the timer runs every clock. The stored value therefore shows each channel's latency to within one cycle and tells the two edge polarities apart. Reload is compared against plain wrap, and software-write capture against a normal byte write in the same channel.

// File: rtl/tmr_cc_pkg.sv
`timescale 1ns/1ps
package tmr_cc_pkg;
   typedef enum logic [1:0] {
      CC_OFF = 2'b00,
      CC_PIN = 2'b01,
      CC_CMP = 2'b10,
      CC_SWR = 2'b11
   } cc_mode_e;

   localparam int unsigned A_CTRL    = 0;
   localparam int unsigned A_MODE    = 1;
   localparam int unsigned A_CNT_LO  = 2;
   localparam int unsigned A_CNT_HI  = 3;
   localparam int unsigned A_CH_BASE = 4;

   localparam int unsigned B_RUN  = 0;
   localparam int unsigned B_SLOW = 1;
   localparam int unsigned B_RLD  = 2;
   localparam int unsigned B_FLAG = 7;
endpackage

// File: rtl/tmr_cc_prescale.sv
`timescale 1ns/1ps
module tmr_cc_prescale #(
   parameter int unsigned DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic slow,
   output logic tick
);
   localparam int unsigned PW = $clog2(DIV);

   if (DIV < 2) begin : g_bad_div
      $error("tmr_cc_prescale: DIV must be at least 2");
   end

   logic [PW-1:0] pre_q;
   logic          last;

   assign last = (pre_q == PW'(DIV - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)              pre_q <= '0;
      else if (!run || !slow)  pre_q <= '0;
      else if (last)           pre_q <= '0;
      else                     pre_q <= pre_q + PW'(1);
   end

   always_comb tick = run && (!slow || last);

   // R3: the divider never leaves its range
   a_r3_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
      pre_q <= PW'(DIV - 1));
   // R3: in slow mode a tick is followed by at least one idle cycle
   a_r3_slow_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && slow && run) |=> !tick || !slow);
endmodule

// File: rtl/tmr_cc_chan.sv
`timescale 1ns/1ps
module tmr_cc_chan
   import tmr_cc_pkg::*;
#(
   parameter int unsigned W       = 16,
   parameter bit          HAS_PIN = 1'b1,
   parameter bit          FALL    = 1'b0,
   parameter int unsigned LAT     = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  cc_mode_e     mode,
   input  logic         pin,
   input  logic [W-1:0] cnt,
   input  logic         wr_lo,
   input  logic         wr_hi,
   input  logic [7:0]   wdata,
   input  logic         ovf,
   output logic [W-1:0] value,
   output logic         pwm
);
   if (W != 16) begin : g_bad_w
      $error("tmr_cc_chan: W must be 16 (two byte lanes)");
   end
   if (LAT != 1 && LAT != 2) begin : g_bad_lat
      $error("tmr_cc_chan: LAT must be 1 or 2");
   end

   logic pin_in;
   logic s1_q, s2_q, s3_q;
   logic edge_raw;
   logic cap_evt;
   logic pin_cap;
   logic sw_cap;

   assign pin_in = HAS_PIN ? pin : FALL;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_q <= FALL;
         s2_q <= FALL;
         s3_q <= FALL;
      end else begin
         s1_q <= pin_in;
         s2_q <= s1_q;
         s3_q <= s2_q;
      end
   end

   assign edge_raw = FALL ? (s3_q && !s2_q) : (s2_q && !s3_q);

   if (LAT == 2) begin : g_lat2
      logic edge_d_q;
      always_ff @(posedge clk) begin
         if (!rst_n) edge_d_q <= 1'b0;
         else        edge_d_q <= edge_raw;
      end
      assign cap_evt = edge_d_q;
   end else begin : g_lat1
      assign cap_evt = edge_raw;
   end

   assign pin_cap = (mode == CC_PIN) && cap_evt;
   assign sw_cap  = (mode == CC_SWR) && wr_lo;

   always_ff @(posedge clk) begin
      if (!rst_n)                 value <= '0;
      else if (pin_cap || sw_cap) value <= cnt;
      else if (wr_lo)             value[7:0] <= wdata;
      else if (wr_hi)             value[W-1:8] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                      pwm <= 1'b0;
      else if (mode != CC_CMP || ovf)  pwm <= 1'b0;
      else if (cnt == value)           pwm <= 1'b1;
   end

   // R6: overflow always drops the compare output
   a_r6_pwm_ovf_low: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> !pwm);
   // R9: a software-write capture stores the whole count
   a_r9_sw_capture: assert property (@(posedge clk) disable iff (!rst_n)
      sw_cap |=> value == $past(cnt));
   // R10: an idle channel with no write keeps its value
   a_r10_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == CC_OFF && !wr_lo && !wr_hi) |=> $stable(value));
endmodule

// File: rtl/tmr_cc4.sv
`timescale 1ns/1ps
module tmr_cc4
   import tmr_cc_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DIV    = 12,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic [NUM_CH-2:0] cap_pin,
   output logic [NUM_CH-1:0] pwm_out,
   output logic              irq
);
   localparam int unsigned MODE_W = 2 * NUM_CH;
   localparam int unsigned TOP_A  = A_CH_BASE + 2 * NUM_CH;

   if (CNT_W != 16) begin : g_bad_w
      $error("tmr_cc4: CNT_W must be 16");
   end
   if (MODE_W != 8) begin : g_bad_ch
      $error("tmr_cc4: the mode register holds exactly four 2-bit fields");
   end
   if (TOP_A > (1 << ADDR_W)) begin : g_bad_a
      $error("tmr_cc4: ADDR_W too small for the register map");
   end

   logic              run_q, slow_q, rld_q, flag_q;
   logic [MODE_W-1:0] mode_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  ch_val [NUM_CH];
   logic [NUM_CH-1:0] pin_w;
   logic              tick, ovf_tick;
   logic              ctrl_wr, mode_wr, cnt_wr_lo, cnt_wr_hi, cnt_wr;

   assign ctrl_wr   = reg_wr && reg_addr == ADDR_W'(A_CTRL);
   assign mode_wr   = reg_wr && reg_addr == ADDR_W'(A_MODE);
   assign cnt_wr_lo = reg_wr && reg_addr == ADDR_W'(A_CNT_LO);
   assign cnt_wr_hi = reg_wr && reg_addr == ADDR_W'(A_CNT_HI);
   assign cnt_wr    = cnt_wr_lo || cnt_wr_hi;

   tmr_cc_prescale #(.DIV(DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run_q), .slow(slow_q), .tick(tick)
   );

   assign ovf_tick = tick && !cnt_wr && (&cnt_q);

   always_ff @(posedge clk) begin
      if (!rst_n)         cnt_q <= '0;
      else if (cnt_wr_lo) cnt_q[7:0] <= reg_wdata;
      else if (cnt_wr_hi) cnt_q[CNT_W-1:8] <= reg_wdata;
      else if (ovf_tick)  cnt_q <= rld_q ? ch_val[0] : '0;
      else if (tick)      cnt_q <= cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         slow_q <= 1'b0;
         rld_q  <= 1'b0;
         mode_q <= '0;
      end else begin
         if (ctrl_wr) begin
            run_q  <= reg_wdata[B_RUN];
            slow_q <= reg_wdata[B_SLOW];
            rld_q  <= reg_wdata[B_RLD];
         end
         if (mode_wr) mode_q <= reg_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                           flag_q <= 1'b0;
      else if (ovf_tick)                    flag_q <= 1'b1;
      else if (ctrl_wr && reg_wdata[B_FLAG]) flag_q <= 1'b0;
   end

   assign irq = flag_q;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam int unsigned LO_A = A_CH_BASE + 2 * i;
      if (i < NUM_CH - 1) begin : g_pin
         assign pin_w[i] = cap_pin[i];
      end else begin : g_nopin
         assign pin_w[i] = 1'b0;
      end
      tmr_cc_chan #(
         .W(CNT_W), .HAS_PIN(i < NUM_CH - 1), .FALL(i == 0), .LAT((i == 0) ? 1 : 2)
      ) u_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .mode  (cc_mode_e'(mode_q[2*i +: 2])),
         .pin   (pin_w[i]),
         .cnt   (cnt_q),
         .wr_lo (reg_wr && reg_addr == ADDR_W'(LO_A)),
         .wr_hi (reg_wr && reg_addr == ADDR_W'(LO_A + 1)),
         .wdata (reg_wdata),
         .ovf   (ovf_tick),
         .value (ch_val[i]),
         .pwm   (pwm_out[i])
      );
   end

   always_comb begin
      reg_rdata = 8'h00;
      if (reg_addr == ADDR_W'(A_CTRL))
         reg_rdata = {flag_q, 4'b0000, rld_q, slow_q, run_q};
      else if (reg_addr == ADDR_W'(A_MODE))   reg_rdata = mode_q;
      else if (reg_addr == ADDR_W'(A_CNT_LO)) reg_rdata = cnt_q[7:0];
      else if (reg_addr == ADDR_W'(A_CNT_HI)) reg_rdata = cnt_q[CNT_W-1:8];
      for (int i = 0; i < NUM_CH; i++) begin
         if (reg_addr == ADDR_W'(A_CH_BASE + 2 * i))     reg_rdata = ch_val[i][7:0];
         if (reg_addr == ADDR_W'(A_CH_BASE + 2 * i + 1)) reg_rdata = ch_val[i][CNT_W-1:8];
      end
   end

   // R4: the flag holds until a clearing write
   a_r4_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(ctrl_wr && reg_wdata[B_FLAG])) |=> irq);
   // R4: an overflow sets the flag
   a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_tick |=> irq);
   // R4: overflow without reload wraps to zero
   a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_tick && !rld_q) |=> cnt_q == '0);
   // R5: overflow with reload takes channel 0's value
   a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_tick && rld_q) |=> cnt_q == $past(ch_val[0]));
   // R11: a count step with no software write adds one
   a_r11_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr && !(&cnt_q)) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: tb/tmr_cc4_test.sv
`timescale 1ns/100ps
module tmr_cc4_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [3:0] reg_addr = 4'h0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic [2:0] cap_pin = 3'b001;
   logic [3:0] pwm_out;
   logic       irq;

   int nvec = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tmr_cc4 uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_pin(cap_pin),
      .pwm_out(pwm_out), .irq(irq)
   );

   typedef struct packed {
      logic [15:0] pre;
      logic [15:0] cmp;
      logic [7:0]  n;
      logic        pwm;
      logic        irq;
   } vec_t;

   // compare table on channel 2: preload, compare value, clocks run, expected pwm and irq
   localparam vec_t VECS [8] = '{
      '{16'h0100, 16'h0105, 8'd5,  1'b0, 1'b0},
      '{16'h0100, 16'h0105, 8'd6,  1'b1, 1'b0},
      '{16'h0100, 16'h0103, 8'd20, 1'b1, 1'b0},
      '{16'hFFF0, 16'hFFF8, 8'd10, 1'b1, 1'b0},
      '{16'hFFF0, 16'hFFF8, 8'd17, 1'b0, 1'b1},
      '{16'hFFFE, 16'h0002, 8'd5,  1'b1, 1'b1},
      '{16'h0000, 16'h0000, 8'd3,  1'b1, 1'b0},
      '{16'h1234, 16'h1000, 8'd8,  1'b0, 1'b0}
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic wr16(input logic [3:0] a, input logic [15:0] d);
      wr(a, d[7:0]);
      wr(a + 4'd1, d[15:8]);
   endtask

   task automatic rd16(input logic [3:0] a, output logic [15:0] v);
      reg_addr = a;     #0.5 v[7:0]  = reg_rdata;
      reg_addr = a + 1; #0.5 v[15:8] = reg_rdata;
   endtask

   task automatic rd8(input logic [3:0] a, output logic [7:0] v);
      reg_addr = a; #0.5 v = reg_rdata;
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog (R1..R11 run): actual hung, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] v, c;
      logic [7:0]  b;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      rd16(4'd2, v); chk("R1 counter", v, 16'h0000);
      rd8(4'd0, b);  chk("R1 control", {8'h00, b}, 16'h0000);
      rd8(4'd1, b);  chk("R1 mode", {8'h00, b}, 16'h0000);
      rd16(4'd4, v); chk("R1 ch0", v, 16'h0000);
      rd16(4'd10, v); chk("R1 ch3", v, 16'h0000);
      chk("R1 pwm/irq", {11'h0, pwm_out, irq}, 16'h0000);

      // R2: register writes read back
      wr(4'd1, 8'hC6); rd8(4'd1, b); chk("R2 mode readback", {8'h00, b}, 16'h00C6);
      wr(4'd1, 8'h00);
      wr16(4'd6, 16'hBEEF); rd16(4'd6, v); chk("R2 ch1 readback", v, 16'hBEEF);
      wr16(4'd2, 16'hA5C3); rd16(4'd2, v); chk("R2 counter readback", v, 16'hA5C3);

      // R6, R4: compare vectors
      for (int i = 0; i < 8; i++) begin
         wr(4'd0, 8'h80);
         wr(4'd1, 8'h00);
         wr16(4'd8, VECS[i].cmp);
         wr16(4'd2, VECS[i].pre);
         wr(4'd1, 8'h20);
         wr(4'd0, 8'h01);
         repeat (int'(VECS[i].n)) @(posedge clk);
         @(negedge clk);
         chk($sformatf("R6 pwm vector %0d", i), {15'h0, pwm_out[2]}, {15'h0, VECS[i].pwm});
         chk($sformatf("R4 irq vector %0d", i), {15'h0, irq}, {15'h0, VECS[i].irq});
      end
      wr(4'd0, 8'h80);
      wr(4'd1, 8'h00);
      chk("R6 pwm low outside compare", {12'h0, pwm_out}, 16'h0000);

      // R3: slow rate, one count per 12 clocks
      wr16(4'd2, 16'h0000);
      wr(4'd0, 8'h03);
      repeat (23) @(posedge clk);
      @(negedge clk);
      rd16(4'd2, v); chk("R3 slow after 23 clocks", v, 16'h0001);
      @(posedge clk); @(negedge clk);
      rd16(4'd2, v); chk("R3 slow after 24 clocks", v, 16'h0002);
      wr(4'd0, 8'h00);

      // R4: wrap without reload
      wr16(4'd4, 16'h8000);
      wr16(4'd2, 16'hFFFE);
      wr(4'd0, 8'h01);
      repeat (3) @(posedge clk); @(negedge clk);
      rd16(4'd2, v); chk("R4 wrap to zero", v, 16'h0001);
      wr(4'd0, 8'h80);

      // R5: reload from channel 0 (channel 0 idle)
      wr16(4'd2, 16'hFFFE);
      wr(4'd0, 8'h05);
      repeat (3) @(posedge clk); @(negedge clk);
      rd16(4'd2, v); chk("R5 reload from ch0", v, 16'h8001);
      wr(4'd0, 8'h00);
      repeat (5) @(posedge clk); @(negedge clk);
      chk("R4 irq sticky", {15'h0, irq}, 16'h0001);
      rd8(4'd0, b); chk("R4 flag bit 7", {15'h0, b[7]}, 16'h0001);
      wr(4'd0, 8'h80);
      chk("R4 irq cleared", {15'h0, irq}, 16'h0000);

      // R11: software counter write wins over count step
      wr16(4'd2, 16'h00F0);
      wr(4'd0, 8'h01);
      wr(4'd2, 8'h05);
      rd8(4'd2, b); chk("R11 write beats count", {8'h00, b}, 16'h0005);
      wr(4'd0, 8'h00);

      // R7, R8, R10: pin captures, all channels in pin mode
      wr16(4'd10, 16'h5A5A);
      wr(4'd1, 8'h55);
      wr16(4'd2, 16'h0000);
      wr(4'd0, 8'h01);
      repeat (4) @(negedge clk);
      rd16(4'd2, c); cap_pin[0] = 1'b0;
      repeat (3) @(posedge clk); @(negedge clk);
      rd16(4'd4, v); chk("R7 ch0 falling capture", v, c + 16'd2);
      cap_pin[0] = 1'b1;
      repeat (6) @(posedge clk); @(negedge clk);
      rd16(4'd4, v); chk("R7 ch0 ignores rising", v, c + 16'd2);
      @(negedge clk);
      rd16(4'd2, c); cap_pin[1] = 1'b1;
      repeat (4) @(posedge clk); @(negedge clk);
      rd16(4'd6, v); chk("R8 ch1 rising capture", v, c + 16'd3);
      rd16(4'd2, c); cap_pin[2] = 1'b1;
      repeat (4) @(posedge clk); @(negedge clk);
      rd16(4'd8, v); chk("R8 ch2 rising capture", v, c + 16'd3);
      rd16(4'd6, c);
      cap_pin[1] = 1'b0;
      repeat (6) @(posedge clk); @(negedge clk);
      rd16(4'd6, v); chk("R8 ch1 ignores falling", v, c);
      rd16(4'd10, v); chk("R10 ch3 no pin capture", v, 16'h5A5A);
      wr(4'd1, 8'h00);
      rd16(4'd6, c);
      @(negedge clk) cap_pin[1] = 1'b1;
      repeat (6) @(posedge clk); @(negedge clk);
      rd16(4'd6, v); chk("R10 idle channel ignores edge", v, c);
      wr(4'd0, 8'h00);

      // R9: software-write capture versus plain write on channel 1
      wr16(4'd2, 16'h4321);
      wr(4'd1, 8'h0C);
      wr(4'd6, 8'hAA);
      rd16(4'd6, v); chk("R9 write capture", v, 16'h4321);
      wr(4'd1, 8'h00);
      wr(4'd6, 8'h77);
      rd16(4'd6, v); chk("R2 plain low write", v, 16'h4377);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule